// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns an inbound PCI DMA address into a system memory address. Four programmable windows each hold a base, a size mask and a translated base. A window either maps directly onto a contiguous block of system memory or uses scatter-gather mapping, where an 8-byte page table entry is read from memory and names an 8 KB system page.

Addresses at or below 2^32-1 are single-address-cycle and are matched against the windows in a fixed priority order. A control bit can blank out the 512 KB range from 0x80000 to 0xFFFFF. Two double-address-cycle paths also exist. A large direct window takes the low 35 address bits straight through. Window 3 can instead be switched into a dual-address mode, where it serves a scatter-gather range above 2^43 in place of its single-address-cycle range.

Software programs the windows through a simple register port. A translation is requested with a valid/ready handshake. The result comes back as a one-cycle response pulse that carries a permission flag.

Top module: `pci_dma_xlate`

## Requirements
- R1: Register select `csr_addr` 0..3 is window base i, 4..7 is window mask i, 8..11 is translated base i, and 12 is control; 13..15 read zero. Stored bits are: base 31:20, 1 and 0; mask 31:20; translated base 34:10; control 6 and 5. All other bits read zero. After reset every register reads zero except base 3.
- R2: Base 3 always reads bit 1 as 1, so it resets to 0x2. It also keeps bit 39, the dual-address enable.
- R3: When control bit 5 is set, a single-address-cycle address from 0x80000 to 0xFFFFF fails. 0x7FFFF and 0x100000 are unaffected.
- R4: Windows 0, 1 and 2 are tried in that order, and window 3 last. Window 3 takes part only when its base bit 39 is clear. The lowest hitting window decides the result.
- R5: A window hits an address below 2^32 when base bit 0 is set and (addr AND NOT(mask OR 0xFFFFF)) equals base bits 31:20 shifted to 31:20.
- R6: A hit with base bit 1 clear returns (tba AND NOT m) OR (addr AND m), where m = mask OR 0xFFFFF.
- R7: A hit with base bit 1 set issues one memory read at (tba AND NOT(mask>>10)) OR ((addr AND (mask OR 0xFE000))>>10). The address is held until `mem_ready`.
- R8: A fetched entry with bit 0 set gives the result {entry bits 21:1, addr bits 12:0}. With bit 0 clear the translation fails.
- R9: When control bit 6 is set, an address in [2^40, 2^41) returns its bits 34:0 without any memory read.
- R10: An address in [2^43, 2^44) fetches an entry at (tba3 AND 0x7FFC00000) OR ((addr AND 0xFFFFE000)>>10) when base 3 has bits 39 and 0 set.
- R11: An address that matches no path fails. A failure gives `resp_ok`=0 and `resp_addr`=0, makes no memory read, and, like a direct result, pulses `resp_valid` on the cycle after acceptance.
- R12: Only one translation is in flight. `req_ready` stays low from the acceptance of a scatter-gather request until its entry returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register select |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data (combinational) |
| req_valid | input | 1 | Translate request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | PCI DMA address |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_ok | output | 1 | Translation succeeded |
| resp_addr | output | 35 | System address, zero on failure |
| mem_valid | output | 1 | Page table entry read request |
| mem_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 35 | Page table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Page table entry |

## Verification
The hardest situations to reach are the ones where several conditions interact: two windows that both cover an address, window 3 with its dual-address bit set facing a single-address-cycle address it would otherwise match, and the hole edges at 0x7FFFF and 0x80000 with a window that covers address zero. The stimulus reprograms the windows between groups of translations so that each of these overlaps is set up on purpose. A behavioural model in the bench, fed by the same register writes, predicts every outcome. The memory side holds `mem_ready` low for one cycle before accepting, which checks that the fetch address is held and that no new request is taken while the fetch is open.

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [3:0]  csr_addr,
  input  logic [63:0] csr_wdata,
  output logic [63:0] csr_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_addr,
  output logic        resp_valid,
  output logic        resp_ok,
  output logic [34:0] resp_addr,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [34:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [63:0] mem_rdata
);
  localparam int NWIN = 4;
  localparam int PW   = 35;
  localparam logic [31:0] PAGE_LOW = 32'h000F_FFFF;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT} st_t;
  st_t st;

  logic [39:0]   wbase [NWIN];
  logic [31:0]   wmask [NWIN];
  logic [PW-1:0] wtba  [NWIN];
  logic          hole_en, big_en;

  logic [1:0] ridx;
  assign ridx = csr_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        wbase[i] <= (i == NWIN - 1) ? 40'h2 : 40'h0;
        wmask[i] <= '0;
        wtba[i]  <= '0;
      end
      hole_en <= 1'b0;
      big_en  <= 1'b0;
    end else if (csr_we) begin
      case (csr_addr[3:2])
        2'd0: begin
          if (ridx == 2'd3)
            wbase[ridx] <= {csr_wdata[39], 7'b0, csr_wdata[31:20], 18'b0, 1'b1, csr_wdata[0]};
          else
            wbase[ridx] <= {8'b0, csr_wdata[31:20], 18'b0, csr_wdata[1:0]};
        end
        2'd1: wmask[ridx] <= {csr_wdata[31:20], 20'b0};
        2'd2: wtba[ridx]  <= {csr_wdata[34:10], 10'b0};
        default: begin
          if (ridx == 2'd0) begin
            hole_en <= csr_wdata[5];
            big_en  <= csr_wdata[6];
          end
        end
      endcase
    end
  end

  always_comb begin
    case (csr_addr[3:2])
      2'd0:    csr_rdata = {24'b0, wbase[ridx]};
      2'd1:    csr_rdata = {32'b0, wmask[ridx]};
      2'd2:    csr_rdata = {29'b0, wtba[ridx]};
      default: csr_rdata = (ridx == 2'd0) ? {57'b0, big_en, hole_en, 5'b0} : 64'b0;
    endcase
  end

  logic        sac, in_hole, big_hit, dac_hit, any_hit;
  logic [NWIN-1:0] hit;
  logic [31:0] mext [NWIN];
  logic [1:0]  sel;

  assign sac     = req_addr[63:32] == 32'b0;
  assign in_hole = hole_en && sac && req_addr[31:19] == 13'h1;
  assign big_hit = big_en && req_addr[63:41] == 23'b0 && req_addr[40];
  assign dac_hit = wbase[3][39] && wbase[3][0] && req_addr[63:44] == 20'b0 && req_addr[43];

  always_comb begin
    for (int i = 0; i < NWIN; i++) begin
      mext[i] = wmask[i] | PAGE_LOW;
      hit[i]  = sac && wbase[i][0] &&
                ((req_addr[31:0] & ~mext[i]) == {wbase[i][31:20], 20'b0});
    end
    hit[NWIN-1] = hit[NWIN-1] && !wbase[NWIN-1][39];
  end

  assign any_hit = |hit;

  always_comb begin
    sel = 2'd0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit[i]) sel = 2'(i);
  end

  logic [PW-1:0] dir_pa, sg_pte, dac_pte;
  assign dir_pa  = (wtba[sel] & ~{3'b0, mext[sel]}) | {3'b0, req_addr[31:0] & mext[sel]};
  assign sg_pte  = (wtba[sel] & ~({3'b0, wmask[sel]} >> 10)) |
                   ({3'b0, req_addr[31:0] & (wmask[sel] | 32'h000F_E000)} >> 10);
  assign dac_pte = (wtba[3] & 35'h7_FFC0_0000) |
                   ({3'b0, req_addr[31:0] & 32'hFFFF_E000} >> 10);

  logic          d_fetch, d_ok;
  logic [PW-1:0] d_val;

  always_comb begin
    d_fetch = 1'b0;
    d_ok    = 1'b0;
    d_val   = '0;
    if (sac) begin
      if (!in_hole && any_hit) begin
        if (wbase[sel][1]) begin
          d_fetch = 1'b1;
          d_val   = sg_pte;
        end else begin
          d_ok  = 1'b1;
          d_val = dir_pa;
        end
      end
    end else if (big_hit) begin
      d_ok  = 1'b1;
      d_val = req_addr[PW-1:0];
    end else if (dac_hit) begin
      d_fetch = 1'b1;
      d_val   = dac_pte;
    end
  end

  logic [12:0] off_q;

  assign req_ready = st == S_IDLE;
  assign mem_valid = st == S_FETCH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      resp_addr  <= '0;
      mem_addr   <= '0;
      off_q      <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (d_fetch) begin
              st       <= S_FETCH;
              mem_addr <= d_val;
              off_q    <= req_addr[12:0];
            end else begin
              resp_valid <= 1'b1;
              resp_ok    <= d_ok;
              resp_addr  <= d_val;
            end
          end
        end
        S_FETCH: if (mem_ready) st <= S_WAIT;
        default: begin
          if (mem_rvalid) begin
            st         <= S_IDLE;
            resp_valid <= 1'b1;
            resp_ok    <= mem_rdata[0];
            resp_addr  <= mem_rdata[0] ? {1'b0, mem_rdata[21:1], off_q} : '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pci_dma_xlate_chk.sv
module pci_dma_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  csr_addr,
  input logic [63:0] csr_rdata,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        resp_ok,
  input logic [34:0] resp_addr,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [34:0] mem_addr,
  input logic        mem_rvalid,
  input logic [63:0] mem_rdata
);
  assert_one_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  assert_fetch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  assert_pte_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[2:0] == 3'b0);

  assert_fail_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ok |-> resp_addr == 35'b0);

  assert_no_resp_in_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !resp_valid);

  assert_pte_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid && !req_ready && !mem_valid |=> resp_valid && resp_ok == $past(mem_rdata[0]));

  assert_sg_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_addr == 4'd3 |-> csr_rdata[1]);
endmodule

bind pci_dma_xlate pci_dma_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rdata(csr_rdata),
  .req_ready(req_ready), .resp_valid(resp_valid), .resp_ok(resp_ok),
  .resp_addr(resp_addr), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
);

// File: tb/tb_pci_dma_xlate.sv
`timescale 1ns/1ps
module tb_pci_dma_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        csr_we = 0;
  logic [3:0]  csr_addr = 0;
  logic [63:0] csr_wdata = 0;
  logic [63:0] csr_rdata;
  logic        req_valid = 0;
  logic        req_ready;
  logic [63:0] req_addr = 0;
  logic        resp_valid, resp_ok;
  logic [34:0] resp_addr;
  logic        mem_valid;
  logic        mem_ready = 0;
  logic [34:0] mem_addr;
  logic        mem_rvalid = 0;
  logic [63:0] mem_rdata = 0;

  always #2.5 clk = ~clk;

  pci_dma_xlate dut (.*);

  int tests = 0, fails = 0;
  bit fetch_ok = 0, resp_exp = 0, done = 0;
  logic [63:0] sh_base [4], sh_mask [4], sh_tba [4], sh_ctl;

  task automatic chk(input bit c, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (mem_valid && !fetch_ok) begin
      fails++; $display("FAIL R11 unexpected fetch act=%h exp=none", mem_addr);
    end
    if (resp_valid && !resp_exp) begin
      fails++; $display("FAIL R11 unexpected resp act=%h exp=none", resp_addr);
    end
  end

  task automatic wr(input int idx, input logic [63:0] d);
    int k = idx % 4;
    @(negedge clk);
    csr_we = 1; csr_addr = 4'(idx); csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
    case (idx / 4)
      0: sh_base[k] = (k == 3) ? ((d & 64'h80_FFF0_0001) | 64'h2) : (d & 64'hFFF0_0003);
      1: sh_mask[k] = d & 64'hFFF0_0000;
      2: sh_tba[k]  = d & 64'h7_FFFF_FC00;
      default: if (k == 0) sh_ctl = d & 64'h60;
    endcase
  endtask

  task automatic rd(input int idx, input string tag);
    logic [63:0] e;
    int k = idx % 4;
    case (idx / 4)
      0: e = sh_base[k];
      1: e = sh_mask[k];
      2: e = sh_tba[k];
      default: e = (k == 0) ? sh_ctl : 64'h0;
    endcase
    @(negedge clk);
    csr_addr = 4'(idx);
    #1;
    chk(csr_rdata == e, tag, csr_rdata, e);
  endtask

  function automatic void model(input logic [63:0] a, output int kind, output logic [63:0] v);
    kind = 0; v = 0;
    if (a < 64'h1_0000_0000) begin
      if (sh_ctl[5] && a >= 64'h80000 && a <= 64'hFFFFF) return;
      for (int i = 0; i < 4; i++) begin
        logic [63:0] m;
        m = sh_mask[i] | 64'hFFFFF;
        if (i == 3 && sh_base[3][39]) continue;
        if (sh_base[i][0] && ((a & ~m) == (sh_base[i] & 64'hFFF0_0000))) begin
          if (sh_base[i][1]) begin
            kind = 2;
            v = (sh_tba[i] & ~(sh_mask[i] >> 10)) | ((a & (sh_mask[i] | 64'hFE000)) >> 10);
          end else begin
            kind = 1;
            v = (sh_tba[i] & ~m) | (a & m);
          end
          return;
        end
      end
    end else if (a >= 64'h100_0000_0000 && a < 64'h200_0000_0000 && sh_ctl[6]) begin
      kind = 1; v = a & 64'h7_FFFF_FFFF;
    end else if (a >= 64'h800_0000_0000 && a < 64'h1000_0000_0000 && sh_base[3][39] && sh_base[3][0]) begin
      kind = 2; v = (sh_tba[3] & 64'h7_FFC0_0000) | ((a & 64'hFFFF_E000) >> 10);
    end
  endfunction

  task automatic xl(input logic [63:0] a, input logic [63:0] pte, input string tag);
    int kind;
    logic [63:0] v, eok, epa;
    model(a, kind, v);
    fetch_ok = (kind == 2);
    resp_exp = 1;
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (kind == 2) begin
      chk(mem_valid && mem_addr == v[34:0], {tag, " fetch addr"}, {29'b0, mem_addr}, v);
      chk(!req_ready, "R12 busy during fetch", {63'b0, req_ready}, 0);
      @(negedge clk);
      chk(mem_valid && mem_addr == v[34:0], "R7 held until ready", {29'b0, mem_addr}, v);
      mem_ready = 1;
      @(negedge clk);
      mem_ready = 0;
      chk(!resp_valid && !req_ready, "R12 waiting data", {63'b0, req_ready}, 0);
      @(negedge clk);
      mem_rvalid = 1; mem_rdata = pte;
      @(negedge clk);
      mem_rvalid = 0;
      eok = {63'b0, pte[0]};
      epa = pte[0] ? {30'b0, pte[21:1], a[12:0]} : 64'h0;
    end else begin
      eok = (kind == 1) ? 64'h1 : 64'h0;
      epa = v;
    end
    chk(resp_valid, {tag, " resp_valid"}, {63'b0, resp_valid}, 1);
    chk({63'b0, resp_ok} == eok, {tag, " ok"}, {63'b0, resp_ok}, eok);
    chk({29'b0, resp_addr} == epa, {tag, " addr"}, {29'b0, resp_addr}, epa);
    @(negedge clk);
    resp_exp = 0; fetch_ok = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      sh_base[i] = (i == 3) ? 64'h2 : 64'h0;
      sh_mask[i] = 0; sh_tba[i] = 0;
    end
    sh_ctl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_valid, "R1 reset idle", {63'b0, req_ready}, 1);
    for (int i = 0; i < 16; i++) rd(i, "R1 R2 reset value");

    for (int i = 0; i < 13; i++) wr(i, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int i = 0; i < 16; i++) rd(i, "R1 R2 write mask");
    wr(3, 64'h0);
    rd(3, "R2 sg bit forced");

    for (int i = 0; i < 13; i++) wr(i, 64'h0);
    xl(64'h0000_1000, 0, "R11 all disabled");

    wr(0, 64'h4000_0001); wr(4, 64'h00F0_0000); wr(8, 64'h1_2300_0000);
    xl(64'h40AB_CDEF, 0, "R6 direct");
    xl(64'h4000_0000, 0, "R5 hit low edge");
    xl(64'h40FF_FFFF, 0, "R5 hit high edge");
    xl(64'h4100_0000, 0, "R5 miss");

    wr(1, 64'h4000_0001); wr(5, 64'h00F0_0000); wr(9, 64'h5_0000_0000);
    xl(64'h4012_3456, 0, "R4 window0 first");
    wr(0, 64'h4000_0000);
    xl(64'h4012_3456, 0, "R4 window1 after disable");

    wr(2, 64'h8000_0003); wr(6, 64'h0010_0000); wr(10, 64'h2_0000_0000);
    xl(64'h801F_E008, 64'h0000_0000_0012_3457, "R7 R8 sg valid");
    xl(64'h8000_2468, 64'h0000_0000_003F_FFFF, "R8 sg max frame");
    xl(64'h8010_0000, 64'h0000_0000_0012_3456, "R8 sg invalid");

    wr(0, 64'h0000_0001); wr(4, 64'h0); wr(8, 64'h6_0000_0000);
    xl(64'h0009_0000, 0, "R3 hole off");
    wr(12, 64'h20);
    rd(12, "R1 control");
    xl(64'h0008_0000, 0, "R3 hole low");
    xl(64'h000F_FFFF, 0, "R3 hole high");
    xl(64'h0007_FFFF, 0, "R3 below hole");

    wr(3, 64'hC000_0001); wr(7, 64'h0); wr(11, 64'h3_0000_0400);
    xl(64'hC001_2340, 64'h0000_0000_0000_0A01, "R4 window3 sac");
    wr(3, 64'h80_C000_0001);
    rd(3, "R2 dac bit kept");
    xl(64'hC001_2340, 0, "R4 window3 excluded");
    xl(64'h800_1234_6008, 64'h0000_0000_0002_0003, "R10 dac sg");
    xl(64'hFFF_FFFF_E000, 64'h0000_0000_0000_0000, "R10 dac invalid");
    xl(64'h1000_0000_0000, 0, "R11 above dac range");

    xl(64'h100_2345_6789, 0, "R9 big off");
    wr(12, 64'h60);
    xl(64'h100_2345_6789, 0, "R9 big direct");
    xl(64'h1FF_FFFF_FFFF, 0, "R9 big top");
    xl(64'h200_0000_0000, 0, "R11 above big");
    xl(64'h1_0000_0000, 0, "R11 gap");

    wr(3, 64'h0);
    xl(64'h800_1234_6008, 0, "R10 dac disabled");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule